// File: doc/BRIEF.md
# NAND Physical Page Layout Sequencer

This block follows a raw NAND page one byte at a time and decides, for each byte, which stream it belongs to. A page on the medium holds a short metadata field, then each ECC packet as its data bytes followed by its parity bytes, with the bad-block-marker bytes placed at the physical offset that equals the page data size. That offset falls inside the last packet, so the last packet's data is split into a head before the marker and a tail after it. The sequencer gives each byte a destination code, a running index into the page data buffer, and that byte's offset in the logical spare buffer.

In the logical spare buffer the marker bytes come first, then the metadata, then the parity field of every packet in packet order. There are no free bytes. The parity size per packet is computed from the correction strength: strength times 15 bits, rounded up to whole bytes. Software pulses `start_i` before a page and then presents one `byte_vld_i` strobe for each byte moved over the flash bus. The block pulses `done_o` once the last parity byte of the final packet has been routed.

The parameters must place the marker inside the last packet: the metadata size plus the parity bytes of all packets but the last must be smaller than the packet size.

Top module: `page_layout_seq`

## Requirements
- R1: After `start_i`, the first META_BYTES accepted bytes (4 by default) are routed with destination code 1 (spare), at logical spare offsets BBM_BYTES, BBM_BYTES+1, and so on.
- R2: Each packet's data bytes are routed with code 0, followed by ECC_BYTES parity bytes with code 1. ECC_BYTES = ceil(ECC_STRENGTH*15/8), which is 8 at strength 4. Code 3 is never produced.
- R3: The byte at physical offset PAGE_BYTES and the BBM_BYTES-1 bytes after it are routed with code 2 at spare offsets 0 to BBM_BYTES-1. The remaining data bytes of the interrupted packet follow, then that packet's parity bytes.
- R4: Parity byte j of packet k has logical spare offset BBM_BYTES + META_BYTES + k*ECC_BYTES + j.
- R5: `data_idx_o` is the number of data bytes routed since start, so data bytes get the indices 0 to PAGE_BYTES-1 in order. Spare and marker bytes leave it unchanged. During a data byte, `spare_idx_o` holds the offset of the last spare or marker byte routed.
- R6: A cycle with `byte_vld_i` low routes nothing (`route_vld_o` low) and does not advance the position.
- R7: `done_o` is high for exactly the one cycle after the last parity byte of the final packet is accepted. After that, strobes are not routed and `data_idx_o` stays unchanged until the next start.
- R8: `start_i` returns the position to 0 from any point, including mid-page. A strobe in the same cycle as `start_i` is not routed.
- R9: After reset, `route_vld_o` and `done_o` are low and strobes are ignored until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a page; position returns to 0 |
| byte_vld_i | input | 1 | One raw page byte is present this cycle |
| route_vld_o | output | 1 | The present byte is routed (the routing outputs are valid) |
| dest_o | output | 2 | Destination: 0 data, 1 metadata/parity, 2 bad-block marker |
| data_idx_o | output | $clog2(PAGE_BYTES+1) | Index of the byte in the data buffer |
| spare_idx_o | output | $clog2(SPARE_BYTES+1) | Logical spare offset of the byte |
| done_o | output | 1 | One-cycle pulse after the final parity byte |

## Verification
The bench concentrates on the split packet. A design that checked for the marker only at a packet boundary would route all 32 bytes of the last packet as data, and a design that reset its per-packet count at the marker would emit too many tail bytes before the parity; both show up as wrong codes at physical offsets 128 to 165. The logical spare offsets are checked for every metadata, marker and parity byte, which catches a parity size that rounds down or an offset that leaves out the marker or the metadata. Pages are also walked with idle cycles between strobes and with a restart in mid-page, and strobes that arrive after the done pulse are checked to be ignored.

// File: rtl/page_layout_pkg.sv
// Shared types for the page layout sequencer.
// Assumes: destination codes are decoded by neighbouring buffer logic.
package page_layout_pkg;

    typedef enum logic [1:0] {
        DEST_DATA  = 2'd0,
        DEST_SPARE = 2'd1,
        DEST_BBM   = 2'd2
    } dest_e;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_META,
        SEG_DATA,
        SEG_ECC,
        SEG_BBM
    } seg_e;

    // Map a physical segment onto the stream it feeds.
    function automatic dest_e seg_to_dest(seg_e s);
        case (s)
            SEG_META, SEG_ECC: return DEST_SPARE;
            SEG_BBM:           return DEST_BBM;
            default:           return DEST_DATA;
        endcase
    endfunction

endpackage

// File: rtl/layout_walker.sv
// Walks the physical page segment by segment: metadata, then packets as
// data + parity, with the marker area inserted at physical offset PAGE_BYTES.
// Assumes: the marker falls strictly inside the last packet's data.
module layout_walker
    import page_layout_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int PKT_BYTES  = 32,
    parameter int ECC_BYTES  = 8,
    parameter int META_BYTES = 4,
    parameter int BBM_BYTES  = 2,
    parameter int CNT_W      = 6,
    parameter int PKT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_vld_i,
    output logic             accept_o,
    output seg_e             seg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [PKT_W-1:0] pkt_o,
    output logic             done_o
);
    localparam int NUM_PKTS = PAGE_BYTES / PKT_BYTES;
    localparam int TOTAL    = META_BYTES + PAGE_BYTES + NUM_PKTS * ECC_BYTES + BBM_BYTES;
    localparam int POS_W    = $clog2(TOTAL + 1);

    seg_e             seg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dcnt_q;
    logic [PKT_W-1:0] pkt_q;
    logic [POS_W-1:0] pos_q;
    logic             bbm_seen_q;
    logic             done_q;

    // A byte is routed only while a page is in progress and no start is pending.
    assign accept_o = byte_vld_i && !start_i && (seg_q != SEG_IDLE);

    // Segment, per-segment counters and physical position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q      <= SEG_IDLE;
            cnt_q      <= '0;
            dcnt_q     <= '0;
            pkt_q      <= '0;
            pos_q      <= '0;
            bbm_seen_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                seg_q      <= SEG_META;
                cnt_q      <= '0;
                dcnt_q     <= '0;
                pkt_q      <= '0;
                pos_q      <= '0;
                bbm_seen_q <= 1'b0;
            end else if (accept_o) begin
                pos_q <= pos_q + 1'b1;
                case (seg_q)
                    SEG_META: begin
                        if (cnt_q == CNT_W'(META_BYTES - 1)) begin
                            seg_q <= SEG_DATA;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    SEG_DATA: begin
                        if (!bbm_seen_q && pos_q == POS_W'(PAGE_BYTES - 1)) begin
                            seg_q  <= SEG_BBM;
                            cnt_q  <= '0;
                            dcnt_q <= dcnt_q + 1'b1;
                        end else if (dcnt_q == CNT_W'(PKT_BYTES - 1)) begin
                            seg_q  <= SEG_ECC;
                            cnt_q  <= '0;
                            dcnt_q <= '0;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end
                    SEG_BBM: begin
                        if (cnt_q == CNT_W'(BBM_BYTES - 1)) begin
                            seg_q      <= SEG_DATA;
                            cnt_q      <= '0;
                            bbm_seen_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    SEG_ECC: begin
                        if (cnt_q == CNT_W'(ECC_BYTES - 1)) begin
                            cnt_q <= '0;
                            if (pkt_q == PKT_W'(NUM_PKTS - 1)) begin
                                seg_q  <= SEG_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                seg_q <= SEG_DATA;
                                pkt_q <= pkt_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: seg_q <= SEG_IDLE;
                endcase
            end
        end
    end

    assign seg_o  = seg_q;
    assign cnt_o  = cnt_q;
    assign pkt_o  = pkt_q;
    assign done_o = done_q;

endmodule

// File: rtl/layout_index.sv
// Produces the destination code, the data-buffer index and the logical
// spare offset (marker, metadata, then parity fields) of the present byte.
// Assumes: seg/cnt/pkt come from layout_walker in the same cycle.
module layout_index
    import page_layout_pkg::*;
#(
    parameter int ECC_BYTES  = 8,
    parameter int META_BYTES = 4,
    parameter int BBM_BYTES  = 2,
    parameter int CNT_W      = 6,
    parameter int PKT_W      = 3,
    parameter int DIDX_W     = 8,
    parameter int SIDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              accept_i,
    input  seg_e              seg_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PKT_W-1:0]  pkt_i,
    output logic [1:0]        dest_o,
    output logic [DIDX_W-1:0] data_idx_o,
    output logic [SIDX_W-1:0] spare_idx_o
);
    logic [DIDX_W-1:0] didx_q;
    logic [SIDX_W-1:0] last_sp_q;
    logic [SIDX_W-1:0] sp_off;
    dest_e             dest;

    assign dest = seg_to_dest(seg_i);

    // Logical spare offset of the current segment byte.
    always_comb begin
        case (seg_i)
            SEG_BBM:  sp_off = SIDX_W'(cnt_i);
            SEG_META: sp_off = SIDX_W'(BBM_BYTES) + SIDX_W'(cnt_i);
            SEG_ECC:  sp_off = SIDX_W'(BBM_BYTES + META_BYTES)
                             + SIDX_W'(pkt_i) * SIDX_W'(ECC_BYTES) + SIDX_W'(cnt_i);
            default:  sp_off = last_sp_q;
        endcase
    end

    // Data index advances on data bytes; the last spare offset is kept for data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            didx_q    <= '0;
            last_sp_q <= '0;
        end else if (start_i) begin
            didx_q    <= '0;
            last_sp_q <= '0;
        end else if (accept_i) begin
            if (dest == DEST_DATA) didx_q <= didx_q + 1'b1;
            else                   last_sp_q <= sp_off;
        end
    end

    assign dest_o      = dest;
    assign data_idx_o  = didx_q;
    assign spare_idx_o = sp_off;

endmodule

// File: rtl/page_layout_seq.sv
// Top of the page layout sequencer: routes each raw page byte to the data,
// spare or bad-block-marker stream and gives its buffer indices.
// Assumes: META_BYTES + (pages packets - 1) * parity bytes < PKT_BYTES.
module page_layout_seq #(
    parameter int PAGE_BYTES   = 128,
    parameter int PKT_BYTES    = 32,
    parameter int ECC_STRENGTH = 4,
    parameter int FIELD_BITS   = 15,
    parameter int META_BYTES   = 4,
    parameter int BBM_BYTES    = 2,
    localparam int NUM_PKTS    = PAGE_BYTES / PKT_BYTES,
    localparam int ECC_BYTES   = (ECC_STRENGTH * FIELD_BITS + 7) / 8,
    localparam int SPARE_BYTES = BBM_BYTES + META_BYTES + NUM_PKTS * ECC_BYTES,
    localparam int DIDX_W      = $clog2(PAGE_BYTES + 1),
    localparam int SIDX_W      = $clog2(SPARE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_vld_i,
    output logic              route_vld_o,
    output logic [1:0]        dest_o,
    output logic [DIDX_W-1:0] data_idx_o,
    output logic [SIDX_W-1:0] spare_idx_o,
    output logic              done_o
);
    import page_layout_pkg::*;

    localparam int MAX_SEG = (PKT_BYTES > ECC_BYTES) ? PKT_BYTES : ECC_BYTES;
    localparam int CNT_W   = $clog2(MAX_SEG + META_BYTES + BBM_BYTES + 1);
    localparam int PKT_W   = $clog2(NUM_PKTS + 1);

    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic [PKT_W-1:0] pkt;
    logic             accept;

    layout_walker #(
        .PAGE_BYTES(PAGE_BYTES), .PKT_BYTES(PKT_BYTES), .ECC_BYTES(ECC_BYTES),
        .META_BYTES(META_BYTES), .BBM_BYTES(BBM_BYTES), .CNT_W(CNT_W), .PKT_W(PKT_W)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .accept_o(accept), .seg_o(seg), .cnt_o(cnt), .pkt_o(pkt), .done_o(done_o)
    );

    layout_index #(
        .ECC_BYTES(ECC_BYTES), .META_BYTES(META_BYTES), .BBM_BYTES(BBM_BYTES),
        .CNT_W(CNT_W), .PKT_W(PKT_W), .DIDX_W(DIDX_W), .SIDX_W(SIDX_W)
    ) u_index (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_i(accept),
        .seg_i(seg), .cnt_i(cnt), .pkt_i(pkt),
        .dest_o(dest_o), .data_idx_o(data_idx_o), .spare_idx_o(spare_idx_o)
    );

    assign route_vld_o = accept;

endmodule

// File: rtl/page_layout_sva.sv
// Property checker for page_layout_seq, attached by bind below.
// Assumes: observes only the top-level ports.
module page_layout_sva #(
    parameter int BBM_BYTES = 2,
    parameter int DIDX_W    = 8,
    parameter int SIDX_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              byte_vld_i,
    input logic              route_vld_o,
    input logic [1:0]        dest_o,
    input logic [DIDX_W-1:0] data_idx_o,
    input logic [SIDX_W-1:0] spare_idx_o,
    input logic              done_o
);
    AST_DEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        route_vld_o |-> dest_o != 2'd3); // R2

    AST_BBM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld_o && dest_o == 2'd2) |-> spare_idx_o < SIDX_W'(BBM_BYTES)); // R3

    AST_DIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld_o && dest_o == 2'd0) |=> data_idx_o == $past(data_idx_o) + 1'b1); // R5

    AST_DIDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld_o && dest_o != 2'd0) |=> $stable(data_idx_o)); // R5

    AST_NO_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |-> !route_vld_o); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !route_vld_o); // R7

    AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !route_vld_o); // R8

endmodule

bind page_layout_seq page_layout_sva #(
    .BBM_BYTES(BBM_BYTES), .DIDX_W(DIDX_W), .SIDX_W(SIDX_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .route_vld_o(route_vld_o), .dest_o(dest_o), .data_idx_o(data_idx_o),
    .spare_idx_o(spare_idx_o), .done_o(done_o)
);

// File: tb/page_layout_seq_bench.sv
// Bench for page_layout_seq with default parameters:
// page 128, packet 32, parity 8, metadata 4, marker 2.
module page_layout_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic       route_vld_o;
    logic [1:0] dest_o;
    logic [7:0] data_idx_o;
    logic [5:0] spare_idx_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Physical runs {dest[1:0], length[7:0], spare base[5:0]} derived from R1-style rules by hand.
    localparam int NRUNS = 11;
    localparam logic [15:0] RUNS [NRUNS] = '{
        {2'd1, 8'd4,  6'd2},   // metadata
        {2'd0, 8'd32, 6'd0},   // packet 0 data
        {2'd1, 8'd8,  6'd6},   // parity 0
        {2'd0, 8'd32, 6'd0},
        {2'd1, 8'd8,  6'd14},
        {2'd0, 8'd32, 6'd0},
        {2'd1, 8'd8,  6'd22},
        {2'd0, 8'd4,  6'd0},   // head of packet 3 (ends at offset 128)
        {2'd2, 8'd2,  6'd0},   // marker
        {2'd0, 8'd28, 6'd0},   // tail of packet 3
        {2'd1, 8'd8,  6'd30}   // parity 3
    };

    page_layout_seq u_page_layout_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .route_vld_o(route_vld_o), .dest_o(dest_o), .data_idx_o(data_idx_o),
        .spare_idx_o(spare_idx_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        byte_vld_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Present one strobe at a negedge and sample the combinational routing.
    task automatic push();
        @(negedge clk);
        byte_vld_i = 1'b1;
        #1;
    endtask

    // Walk one full page; with gaps, an idle cycle precedes every third byte.
    task automatic walk(input bit gaps);
        int dexp = 0;
        int last_sp = 0;
        int nb = 0;
        for (int r = 0; r < NRUNS; r++) begin
            for (int j = 0; j < int'(RUNS[r][13:6]); j++) begin
                int d;
                int sp;
                d = int'(RUNS[r][15:14]);
                if (gaps && (nb % 3 == 2)) begin
                    @(negedge clk);
                    byte_vld_i = 1'b0;
                    #1;
                    chk(route_vld_o == 1'b0, "R6 gap not routed", route_vld_o, 0);
                end
                push();
                sp = (d != 0) ? int'(RUNS[r][5:0]) + j : last_sp;
                chk(route_vld_o == 1'b1, "R1 byte routed", route_vld_o, 1);
                chk(int'(dest_o) == d, (d == 2) ? "R3 marker dest" : "R2 dest", dest_o, d);
                chk(int'(data_idx_o) == dexp, "R5 data index", data_idx_o, dexp);
                chk(int'(spare_idx_o) == sp, (d == 1) ? "R4 spare offset" : "R3 spare offset",
                    spare_idx_o, sp);
                if (d == 0) dexp++;
                else last_sp = sp;
                nb++;
            end
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
        #1;
        chk(done_o == 1'b1, "R7 done after last parity", done_o, 1);
        chk(int'(data_idx_o) == 128, "R5 final data count", data_idx_o, 128);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, strobes ignored before any start.
        @(negedge clk);
        byte_vld_i = 1'b1;
        #1;
        chk(route_vld_o == 1'b0, "R9 no route after reset", route_vld_o, 0);
        chk(done_o == 1'b0, "R9 done low after reset", done_o, 0);
        @(negedge clk);
        #1;
        chk(int'(data_idx_o) == 0, "R9 data index idle", data_idx_o, 0);

        // Full page, back-to-back strobes.
        pulse_start();
        walk(1'b0);
        @(negedge clk);
        #1;
        chk(done_o == 1'b0, "R7 done single cycle", done_o, 1'b0);
        // R7: strobes after done are ignored.
        push();
        chk(route_vld_o == 1'b0, "R7 no route after done", route_vld_o, 0);
        @(negedge clk);
        byte_vld_i = 1'b0;
        #1;
        chk(int'(data_idx_o) == 128, "R7 data index held", data_idx_o, 128);
        chk(done_o == 1'b0, "R7 no second done", done_o, 0);

        // R8: restart mid-page, with a strobe in the start cycle.
        pulse_start();
        for (int i = 0; i < 40; i++) push();
        @(negedge clk);
        start_i = 1'b1;
        byte_vld_i = 1'b1;
        #1;
        chk(route_vld_o == 1'b0, "R8 strobe with start not routed", route_vld_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        byte_vld_i = 1'b0;
        #1;
        chk(int'(data_idx_o) == 0, "R8 data index cleared", data_idx_o, 0);
        // Full page again after restart, with idle gaps (R6).
        walk(1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule